// File: doc/BRIEF.md
# Auxiliary Event-Type Configuration Bank

This block stores the event selections for up to sixteen auxiliary activity-monitor counters and sits behind a system-register access port. Each access presents its instruction encoding fields, a read or write direction and 64 bits of write data. The block decodes the encoding and picks one register. It then decides whether the access completes, traps to a higher exception level, or is undefined. It makes that decision from the current exception level, a user-access enable, per-level trap bits, a hypervisor routing bit and which levels exist.

Reads pass through a priority chain of trap checks that depends on the current level. Writes land only when the access comes from the highest implemented level. If the index is at or beyond the implemented counter count, the access reads as zero and the write is dropped. A write to a register whose counter is currently running is also dropped. An event value larger than the counter's supported maximum is stored as zero, so the value read back is always defined. Every result is registered and appears one cycle after the access strobe.

Top module: `evtTypeBank`

## Requirements
- R1: An access matches only when op0=2'b11, op1=3'b011, crn=4'b1101 and crm[3:1]=3'b111. A non-matching access gives respValid=0 in the following cycle and leaves every stored register unchanged.
- R2: The register index is {crm[0], op2[2:0]}, with crm[0] as the most significant bit.
- R3: A read at level 0 (curEl=0) checks these conditions in order. If userEn=0, it traps to level 2 when el2Enabled=1 and tge=1, and to level 1 otherwise. Next, if el2Enabled=1 and tam2=1, it traps to level 2. Next, if el3Present=1 and tam3=1, it traps to level 3. Otherwise it returns data.
- R4: A read at level 1 checks the level-2 trap (el2Enabled and tam2), then the level-3 trap (el3Present and tam3). A read at level 2 checks only the level-3 trap. A read at level 3 never traps.
- R5: A trap gives trapValid=1, trapEl equal to the target level and trapClass=6'h18. trapEl and trapClass are 0 when there is no trap, and rdData is 0 on a trapped read.
- R6: A write stores only when curEl equals highestEl. At any other level it gives undefOut=1 and leaves the register unchanged. Writes never trap.
- R7: When the index is greater than or equal to numCounters, a read returns 0 without undefOut, and a write is dropped without undefOut.
- R8: A write to index i while cntEnable[i]=1 is dropped, and the stored value stays unchanged.
- R9: Register i accepts event values up to 16'h0FFF + i*16'h1000. A larger written value is stored as 0.
- R10: rdData[63:16] always reads 0, and write data bits [63:16] are discarded.
- R11: respValid, trapValid, trapEl, trapClass, undefOut and rdData are registered and valid in the cycle after the access strobe. They are 0 in any cycle without a response. trapValid and undefOut are never both 1. Reset clears every register and output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 = write, 0 = read |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm; bit 0 is the index MSB |
| op2 | input | 3 | Encoding field op2; low index bits |
| wrData | input | 64 | Write data |
| curEl | input | 2 | Current exception level |
| userEn | input | 1 | Level-0 access enable |
| tam2 | input | 1 | Level-2 trap control |
| tam3 | input | 1 | Level-3 trap control |
| tge | input | 1 | Routes level-0 traps to level 2 |
| el2Enabled | input | 1 | Level 2 is enabled |
| el3Present | input | 1 | Level 3 is implemented |
| highestEl | input | 2 | Highest implemented level |
| numCounters | input | 5 | Implemented counter count, 0 to 16 |
| cntEnable | input | 16 | Per-counter running status |
| rdData | output | 64 | Read data |
| respValid | output | 1 | A matching access was answered |
| trapValid | output | 1 | The access trapped |
| trapEl | output | 2 | Trap target level |
| trapClass | output | 6 | Trap syndrome class |
| undefOut | output | 1 | The access is undefined |

## Verification
The trap chain is swept over every current level combined with all 64 settings of the six control flags. This separates the level-0 routing choice from the later trap checks and shows that each level skips the checks it should ignore. A second sweep reads every index under every counter count from 0 to 16 to locate the read-as-zero boundary. Writes are tried at each register's supported maximum and one above it, at levels below the highest level, against running counters and with each encoding field broken in turn. Each write is followed by a read-back, which shows whether the stored value changed.

// File: rtl/evtTypePkg.sv
package evtTypePkg;
  localparam int IDX_W = 4;
  localparam logic [5:0] TRAP_EC = 6'h18;

  typedef enum logic [1:0] {
    EL_USR = 2'd0,
    EL_KRN = 2'd1,
    EL_HYP = 2'd2,
    EL_MON = 2'd3
  } excLevel_t;

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [IDX_W-1:0] idx;
  } evtStrobe_t;
endpackage

// File: rtl/evtAccessCtrl.sv
module evtAccessCtrl
  import evtTypePkg::*;
#(
  parameter int CNT_W = IDX_W + 1,
  parameter int NUM_REGS = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic [1:0]          op0,
  input  logic [2:0]          op1,
  input  logic [3:0]          crn,
  input  logic [3:0]          crm,
  input  logic [2:0]          op2,
  input  logic [1:0]          curEl,
  input  logic                userEn,
  input  logic                tam2,
  input  logic                tam3,
  input  logic                tge,
  input  logic                el2Enabled,
  input  logic                el3Present,
  input  logic [1:0]          highestEl,
  input  logic [CNT_W-1:0]    numCounters,
  input  logic [NUM_REGS-1:0] cntEnable,
  output evtStrobe_t          strb,
  output logic                respValid,
  output logic                trapValid,
  output logic [1:0]          trapEl,
  output logic [5:0]          trapClass,
  output logic                undefOut
);
  logic             hit, isRead, isWrite, atTop, inRange, trapNeed;
  logic [1:0]       trapTgt;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit     = accValid && (op0 == 2'b11) && (op1 == 3'b011) &&
              (crn == 4'b1101) && (crm[3:1] == 3'b111);
    idx     = {crm[0], op2};
    inRange = {1'b0, idx} < numCounters;
    isRead  = hit && !accWrite;
    isWrite = hit && accWrite;
    atTop   = curEl == highestEl;

    trapNeed = 1'b0;
    trapTgt  = 2'd0;
    unique case (excLevel_t'(curEl))
      EL_USR: begin
        if (!userEn) begin
          trapNeed = 1'b1;
          trapTgt  = (el2Enabled && tge) ? 2'd2 : 2'd1;
        end else if (el2Enabled && tam2) begin
          trapNeed = 1'b1;
          trapTgt  = 2'd2;
        end else if (el3Present && tam3) begin
          trapNeed = 1'b1;
          trapTgt  = 2'd3;
        end
      end
      EL_KRN: begin
        if (el2Enabled && tam2) begin
          trapNeed = 1'b1;
          trapTgt  = 2'd2;
        end else if (el3Present && tam3) begin
          trapNeed = 1'b1;
          trapTgt  = 2'd3;
        end
      end
      EL_HYP: begin
        if (el3Present && tam3) begin
          trapNeed = 1'b1;
          trapTgt  = 2'd3;
        end
      end
      default: ;
    endcase

    strb.idx  = idx;
    strb.rdEn = isRead && !trapNeed && inRange;
    strb.wrEn = isWrite && atTop && inRange && !cntEnable[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      trapValid <= 1'b0;
      trapEl    <= 2'd0;
      trapClass <= 6'd0;
      undefOut  <= 1'b0;
    end else begin
      respValid <= hit;
      trapValid <= isRead && trapNeed;
      trapEl    <= (isRead && trapNeed) ? trapTgt : 2'd0;
      trapClass <= (isRead && trapNeed) ? TRAP_EC : 6'd0;
      undefOut  <= isWrite && !atTop;
    end
  end
endmodule

// File: rtl/evtRegFile.sv
module evtRegFile
  import evtTypePkg::*;
#(
  parameter int             DATA_W   = 64,
  parameter int             EVT_W    = 16,
  parameter logic [EVT_W-1:0] MAX_BASE = 16'h0FFF,
  parameter logic [EVT_W-1:0] MAX_STEP = 16'h1000,
  parameter int             NUM_REGS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strb,
  input  logic [EVT_W-1:0]  wrEvt,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - EVT_W;

  logic [EVT_W-1:0] evtQ   [NUM_REGS];
  logic [EVT_W-1:0] limVec [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gLimit
    assign limVec[g] = EVT_W'(int'(MAX_BASE) + g * int'(MAX_STEP));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) evtQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strb.wrEn && strb.idx == IDX_W'(i))
          evtQ[i] <= (wrEvt > limVec[i]) ? '0 : wrEvt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdEn ? {{PAD_W{1'b0}}, evtQ[strb.idx]} : '0;
  end
endmodule

// File: rtl/evtTypeBank.sv
module evtTypeBank
  import evtTypePkg::*;
#(
  parameter int               DATA_W   = 64,
  parameter int               EVT_W    = 16,
  parameter logic [EVT_W-1:0] MAX_BASE = 16'h0FFF,
  parameter logic [EVT_W-1:0] MAX_STEP = 16'h1000,
  parameter int               NUM_REGS = 1 << IDX_W,
  parameter int               CNT_W    = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic [1:0]          op0,
  input  logic [2:0]          op1,
  input  logic [3:0]          crn,
  input  logic [3:0]          crm,
  input  logic [2:0]          op2,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [1:0]          curEl,
  input  logic                userEn,
  input  logic                tam2,
  input  logic                tam3,
  input  logic                tge,
  input  logic                el2Enabled,
  input  logic                el3Present,
  input  logic [1:0]          highestEl,
  input  logic [CNT_W-1:0]    numCounters,
  input  logic [NUM_REGS-1:0] cntEnable,
  output logic [DATA_W-1:0]   rdData,
  output logic                respValid,
  output logic                trapValid,
  output logic [1:0]          trapEl,
  output logic [5:0]          trapClass,
  output logic                undefOut
);
  evtStrobe_t strb;

  evtAccessCtrl #(.CNT_W(CNT_W), .NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .curEl(curEl), .userEn(userEn), .tam2(tam2), .tam3(tam3), .tge(tge),
    .el2Enabled(el2Enabled), .el3Present(el3Present), .highestEl(highestEl),
    .numCounters(numCounters), .cntEnable(cntEnable), .strb(strb),
    .respValid(respValid), .trapValid(trapValid), .trapEl(trapEl),
    .trapClass(trapClass), .undefOut(undefOut)
  );

  evtRegFile #(
    .DATA_W(DATA_W), .EVT_W(EVT_W), .MAX_BASE(MAX_BASE),
    .MAX_STEP(MAX_STEP), .NUM_REGS(NUM_REGS)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrEvt(wrData[EVT_W-1:0]), .rdData(rdData)
  );
endmodule

// File: rtl/evtTypeBank_chk.sv
module evtTypeBank_chk #(
  parameter int DATA_W = 64,
  parameter int EVT_W  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [1:0]        op0,
  input logic [2:0]        op1,
  input logic [3:0]        crn,
  input logic [3:0]        crm,
  input logic [2:0]        op2,
  input logic [1:0]        curEl,
  input logic [1:0]        highestEl,
  input logic [CNT_W-1:0]  numCounters,
  input logic [DATA_W-1:0] rdData,
  input logic              respValid,
  input logic              trapValid,
  input logic [1:0]        trapEl,
  input logic [5:0]        trapClass,
  input logic              undefOut
);
  logic hitDec, outRange;
  assign hitDec   = accValid && op0 == 2'b11 && op1 == 3'b011 &&
                    crn == 4'b1101 && crm[3:1] == 3'b111;
  assign outRange = {1'b0, crm[0], op2} >= numCounters;

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(trapValid && undefOut));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!trapValid && !undefOut && rdData == '0));

  p_trap_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (trapClass == 6'h18 && trapEl != 2'd0 && rdData == '0));

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:EVT_W] == '0);

  p_low_write_undef_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hitDec && accWrite && curEl != highestEl) |=> (undefOut && !trapValid));

  p_top_read_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hitDec && !accWrite && curEl == 2'd3) |=> !trapValid);

  p_nohit_silent_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !hitDec) |=> !respValid);

  p_range_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hitDec && !accWrite && outRange) |=> (rdData == '0 && !undefOut));
endmodule

bind evtTypeBank evtTypeBank_chk #(.DATA_W(DATA_W), .EVT_W(EVT_W), .CNT_W(CNT_W)) uChk (.*);

// File: tb/evtTypeBank_test.sv
`timescale 1ns/1ps
module evtTypeBank_test;
  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0;
  logic [1:0]  op0 = '0;
  logic [2:0]  op1 = '0;
  logic [3:0]  crn = '0, crm = '0;
  logic [2:0]  op2 = '0;
  logic [63:0] wrData = '0;
  logic [1:0]  curEl = 2'd3, highestEl = 2'd3;
  logic        userEn = 1'b1, tam2 = 1'b0, tam3 = 1'b0, tge = 1'b0;
  logic        el2Enabled = 1'b1, el3Present = 1'b1;
  logic [4:0]  numCounters = 5'd16;
  logic [15:0] cntEnable = '0;
  logic [63:0] rdData;
  logic        respValid, trapValid, undefOut;
  logic [1:0]  trapEl;
  logic [5:0]  trapClass;

  int nChecks = 0, nFails = 0;
  logic [15:0] model [16];

  evtTypeBank uut (.*);

  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lim(input int i);
    return 32'h0FFF + i * 32'h1000;
  endfunction

  // expected {trap, target} per R3/R4
  function automatic logic [2:0] expTrap();
    case (curEl)
      2'd0: if (!userEn) return {1'b1, (el2Enabled && tge) ? 2'd2 : 2'd1};
            else if (el2Enabled && tam2) return 3'b110;
            else if (el3Present && tam3) return 3'b111;
            else return 3'b000;
      2'd1: if (el2Enabled && tam2) return 3'b110;
            else if (el3Present && tam3) return 3'b111;
            else return 3'b000;
      2'd2: if (el3Present && tam3) return 3'b111;
            else return 3'b000;
      default: return 3'b000;
    endcase
  endfunction

  // enc: 0 good; 1..4 break op0, op1, crn, crm[3:1]
  task automatic vec(input bit wr, input int idx, input logic [63:0] d,
                     input int enc, input string req);
    bit          hit, inR, tr;
    logic [2:0]  t;
    logic [63:0] eRd;
    hit = (enc == 0);
    inR = idx < int'(numCounters);
    t   = expTrap();
    tr  = hit && !wr && t[2];
    eRd = (hit && !wr && !tr && inR) ? {48'd0, model[idx]} : 64'd0;
    @(negedge clk);
    accValid = 1'b1;
    accWrite = wr;
    wrData   = d;
    op0 = (enc == 1) ? 2'b10  : 2'b11;
    op1 = (enc == 2) ? 3'b010 : 3'b011;
    crn = (enc == 3) ? 4'b1100 : 4'b1101;
    crm = {(enc == 4) ? 3'b110 : 3'b111, 1'(idx >> 3)};
    op2 = 3'(idx);
    @(negedge clk);
    accValid = 1'b0;
    chk({63'd0, respValid}, {63'd0, hit}, req, "respValid");
    chk({61'd0, trapValid, trapEl}, {61'd0, tr, tr ? t[1:0] : 2'd0}, req, "trap");
    chk({58'd0, trapClass}, {58'd0, tr ? 6'h18 : 6'h00}, req, "trapClass");
    chk({63'd0, undefOut}, {63'd0, hit && wr && curEl != highestEl}, req, "undef");
    chk(rdData, eRd, req, "rdData");
    if (hit && wr && curEl == highestEl && inR && !cntEnable[idx])
      model[idx] = (int'(d[15:0]) > lim(idx)) ? 16'd0 : d[15:0];
  endtask

  task automatic topRead(input int idx, input string req);
    logic [1:0] e;
    logic [4:0] n;
    e = curEl; n = numCounters;
    curEl = 2'd3; numCounters = 5'd16;
    vec(1'b0, idx, 64'd0, 0, req);
    curEl = e; numCounters = n;
  endtask

  initial begin
    #(CLK_NS * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({56'd0, respValid, trapValid, trapEl, trapClass[3:0]}, 64'd0, "R11", "reset outputs");
    chk(rdData, 64'd0, "R11", "reset rdData");
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) topRead(i, "R11");

    // R2, R10: distinct values with junk in the upper bits, read back
    for (int i = 0; i < 16; i++)
      vec(1'b1, i, {48'hDEADBEEFCAFE, 16'h0100 + 16'(i * 16'h0111)}, 0, "R10");
    for (int i = 0; i < 16; i++) topRead(i, "R2");

    // R3, R4, R5: all levels times all flag settings
    for (int el = 0; el < 4; el++)
      for (int f = 0; f < 64; f++) begin
        curEl = 2'(el);
        {userEn, tam2, tam3, tge, el2Enabled, el3Present} = 6'(f);
        vec(1'b0, (el * 64 + f) % 16, 64'd0, 0, el == 0 ? "R3" : "R4");
      end
    {userEn, tam2, tam3, tge, el2Enabled, el3Present} = 6'b100011;
    curEl = 2'd3;

    // R6: writes below the highest level are undefined and leave state
    for (int el = 0; el < 3; el++) begin
      curEl = 2'(el);
      vec(1'b1, 4 + el, 64'h0000_0000_0000_0ABC, 0, "R6");
      topRead(4 + el, "R6");
    end
    highestEl = 2'd2; curEl = 2'd2;
    vec(1'b1, 9, 64'h0000_0000_0000_1234, 0, "R6");
    curEl = 2'd1;
    vec(1'b1, 9, 64'h0000_0000_0000_4321, 0, "R6");
    topRead(9, "R6");
    highestEl = 2'd3; curEl = 2'd3;

    // R8: running counter blocks its own register only
    cntEnable = 16'h0020;
    vec(1'b1, 5, 64'h0000_0000_0000_2222, 0, "R8");
    vec(1'b1, 6, 64'h0000_0000_0000_3333, 0, "R8");
    topRead(5, "R8");
    topRead(6, "R8");
    cntEnable = '0;

    // R9: each register at its limit and one above
    for (int i = 0; i < 16; i++) begin
      vec(1'b1, i, 64'(lim(i)), 0, "R9");
      topRead(i, "R9");
      if (i < 15) begin
        vec(1'b1, i, 64'(lim(i) + 1), 0, "R9");
        topRead(i, "R9");
      end
    end
    for (int i = 0; i < 16; i++)
      vec(1'b1, i, 64'(16'h0042 + i), 0, "R9");

    // R7: every count against every index
    for (int n = 0; n <= 16; n++) begin
      numCounters = 5'(n);
      for (int i = 0; i < 16; i++) vec(1'b0, i, 64'd0, 0, "R7");
    end
    numCounters = 5'd10;
    vec(1'b1, 12, 64'h0000_0000_0000_0777, 0, "R7");
    vec(1'b1, 3, 64'h0000_0000_0000_0555, 0, "R7");
    topRead(12, "R7");
    topRead(3, "R7");
    numCounters = 5'd16;

    // R1: each encoding field broken, read and write
    for (int e = 1; e <= 4; e++) begin
      vec(1'b0, 14, 64'd0, e, "R1");
      vec(1'b1, 14, 64'h0000_0000_0000_0999, e, "R1");
      topRead(14, "R1");
    end

    // R11: idle cycle shows no response
    @(negedge clk);
    chk({61'd0, respValid, trapValid, undefOut}, 64'd0, "R11", "idle outputs");
    chk(rdData, 64'd0, "R11", "idle rdData");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule